// File: doc/BRIEF.md
# Two-Level Histogram Median Selector

This block returns the median of a window of N unsigned 8-bit samples. It avoids a 256-entry histogram by using two 16-entry histograms. The coarse histogram counts the upper nibble of every sample. A cumulative walk over it finds the coarse bin that holds the median, together with the number of samples in all lower coarse bins. The fine histogram is then rebuilt from the lower nibbles of only those samples whose upper nibble matches the chosen coarse bin. A second walk, which resumes from the carried count, picks the lower nibble. Alongside the fine histogram the block keeps a small index memory. From it, the block reports which window slot holds the median.

The window is kept inside the block as N slots, laid out column by column with K rows per column. A load operation fills every slot. A slide operation replaces the oldest column with K new samples. During a slide, the coarse histogram is updated incrementally: each departing sample is removed and each arriving sample is added in the same cycle. The fine histogram is cleared and rebuilt for every result. All work is sequential: one sample per clock while filling or rebuilding, and one bin per clock while walking. Each result is marked by a single-cycle done strobe.

Top module: `hh_median`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `median_o` and `med_idx_o` are all zero.
- R2: A `load_i` pulse while idle raises `busy_o` on the next cycle. The block then accepts exactly N samples on cycles with `smp_valid_i` high, storing the i-th accepted sample in slot i (0 to N-1), and resets the oldest-column base to 0.
- R3: A `slide_i` pulse while idle (and no `load_i`) raises `busy_o` on the next cycle. The block then accepts exactly K samples. Sample r goes to slot base+r, where base is the oldest-column base, and the departing sample in that slot is removed from the coarse counts. After the slide, base advances by K and wraps to 0 when it reaches N.
- R4: `median_o` equals the sample of ascending rank (N+1)/2 (counting from 1) among the N slots. For the window 0x14, 0x44, 0x42, 0xA3, 0xA6, 0xAB, 0xC0, 0xE4, 0xFF the result is 0xA6.
- R5: `med_idx_o` is the highest slot number whose sample equals `median_o`.
- R6: `done_o` rises exactly N + U + L + 2 cycles after the clock edge that accepts the final sample, where U is the upper and L the lower nibble of the median. The worst case is N + 32 cycles, when both nibbles are 15.
- R7: `done_o` is high for exactly one cycle, and `busy_o` falls on the same edge on which `done_o` rises.
- R8: `load_i`, `slide_i` and `smp_valid_i` have no effect while the block is busy after its last sample. `smp_valid_i` has no effect while idle.
- R9: `median_o` and `med_idx_o` change only on the edge that raises `done_o`, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Start a full window load (pulse, idle only) |
| slide_i | input | 1 | Start a one-column slide (pulse, idle only) |
| smp_valid_i | input | 1 | Sample strobe during a fill |
| smp_i | input | SMP_W (8) | Sample value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| median_o | output | SMP_W (8) | Median of the window |
| med_idx_o | output | IDX_W (4) | Highest slot holding the median |

## Verification
The bench targets the case where every sample lands in coarse bin 15 and fine bin 15. A walk that stopped one bin early, or ran past the last bin, would return a wrong value or break the N+32 cycle bound. It repeats the median value several times, so a design that kept the first matching slot instead of the last would report the wrong index. It also slides the window around its full column rotation. A design that removed the wrong departing sample, or forgot to wrap the column base, would drift away from a sorted reference. Finally, it injects stray command and sample strobes while the block is busy or idle. A block that honoured them would corrupt its stored window or restart early.

// File: rtl/hh_median_pkg.sv
// Shared types and helpers for the two-level histogram median selector.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package hh_median_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SCAN_HI,
        ST_BUILD_LO,
        ST_SCAN_LO
    } hh_state_e;

    // Width of one histogram bin: 8 bits suffice below 256 samples.
    function automatic int bin_width(input int n);
        return (n < 256) ? 8 : 16;
    endfunction

endpackage

// File: rtl/hh_win_store.sv
// Window storage: N sample slots, one write port and two combinational
// read ports. Assumes addresses stay below N.
module hh_win_store #(
    parameter int N     = 9,
    parameter int SMP_W = 8,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [SMP_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rda_addr,
    output logic [SMP_W-1:0] rda_data,
    input  logic [IDX_W-1:0] rdb_addr,
    output logic [SMP_W-1:0] rdb_data
);

    logic [SMP_W-1:0] slot_q [N];

    // Per-slot write with synchronous clear.
    for (genvar s = 0; s < N; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[s] <= '0;
            else if (wr_en && (wr_addr == IDX_W'(s)))
                slot_q[s] <= wr_data;
        end
    end

    // Read port A: value departing from the slot being written.
    always_comb begin
        rda_data = '0;
        for (int s = 0; s < N; s++)
            if (rda_addr == IDX_W'(s)) rda_data = slot_q[s];
    end

    // Read port B: sequential walk used when rebuilding the fine histogram.
    always_comb begin
        rdb_data = '0;
        for (int s = 0; s < N; s++)
            if (rdb_addr == IDX_W'(s)) rdb_data = slot_q[s];
    end

endmodule

// File: rtl/hh_hist_hi.sv
// Coarse histogram: one counter per upper-nibble value. One add and one
// remove may happen per cycle; if both hit the same bin the count holds.
// Assumes the caller never removes from an empty bin.
module hh_hist_hi #(
    parameter int NIB_W = 4,
    parameter int BIN_W = 8,
    localparam int NUM_BINS = 1 << NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [NIB_W-1:0] add_bin,
    input  logic             rem_en,
    input  logic [NIB_W-1:0] rem_bin,
    input  logic [NIB_W-1:0] rd_bin,
    output logic [BIN_W-1:0] rd_cnt
);

    logic [BIN_W-1:0] cnt_q [NUM_BINS];

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        logic inc, dec;
        assign inc = add_en && (add_bin == NIB_W'(b));
        assign dec = rem_en && (rem_bin == NIB_W'(b));
        // Counter update: clear, increment, decrement or hold.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                cnt_q[b] <= '0;
            else if (inc && !dec)
                cnt_q[b] <= cnt_q[b] + BIN_W'(1);
            else if (dec && !inc)
                cnt_q[b] <= cnt_q[b] - BIN_W'(1);
        end
    end

    assign rd_cnt = cnt_q[rd_bin];

endmodule

// File: rtl/hh_hist_lo.sv
// Fine histogram plus slot-index memory. Each update increments one bin
// and records the slot number in that bin's index entry; the index memory
// is never cleared, since only entries written in the current build are read.
module hh_hist_lo #(
    parameter int NIB_W = 4,
    parameter int BIN_W = 8,
    parameter int IDX_W = 4,
    localparam int NUM_BINS = 1 << NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             upd_en,
    input  logic [NIB_W-1:0] upd_bin,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [NIB_W-1:0] rd_bin,
    output logic [BIN_W-1:0] rd_cnt,
    output logic [IDX_W-1:0] rd_idx
);

    logic [BIN_W-1:0] cnt_q [NUM_BINS];
    logic [IDX_W-1:0] idx_q [NUM_BINS];

    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        // Bin counter: cleared before each rebuild.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                cnt_q[b] <= '0;
            else if (upd_en && (upd_bin == NIB_W'(b)))
                cnt_q[b] <= cnt_q[b] + BIN_W'(1);
        end
        // Index entry: last slot seen in this bin, no reset.
        always_ff @(posedge clk) begin
            if (upd_en && (upd_bin == NIB_W'(b)))
                idx_q[b] <= upd_idx;
        end
    end

    assign rd_cnt = cnt_q[rd_bin];
    assign rd_idx = idx_q[rd_bin];

endmodule

// File: rtl/hh_scan_step.sv
// One step of a cumulative bin walk: adds the bin count to the running
// total and flags when the total reaches TARGET. Assumes the sum never
// exceeds the window size.
module hh_scan_step #(
    parameter int CNT_W  = 4,
    parameter int BIN_W  = 8,
    parameter int TARGET = 5
) (
    input  logic [CNT_W-1:0] acc_i,
    input  logic [BIN_W-1:0] bin_i,
    output logic [CNT_W-1:0] acc_o,
    output logic             hit_o
);

    logic [CNT_W:0] sum;

    // Running total and threshold compare.
    always_comb begin
        sum   = {1'b0, acc_i} + (CNT_W+1)'(bin_i);
        acc_o = sum[CNT_W-1:0];
        hit_o = (sum >= (CNT_W+1)'(TARGET));
    end

endmodule

// File: rtl/hh_median.sv
// Two-level histogram median selector. Sequence: fill (N or K samples),
// coarse walk (one bin per clock), fine rebuild (one slot per clock),
// fine walk resuming from the carried count, then a done strobe.
// Assumes N is a multiple of K and SMP_W is even.
module hh_median #(
    parameter int N     = 9,
    parameter int K     = 3,
    parameter int SMP_W = 8,
    localparam int NIB_W = SMP_W / 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
    localparam int CNT_W = $clog2(N + 1),
    localparam int BIN_W = hh_median_pkg::bin_width(N),
    localparam int HALF  = (N + 1) / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             slide_i,
    input  logic             smp_valid_i,
    input  logic [SMP_W-1:0] smp_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [SMP_W-1:0] median_o,
    output logic [IDX_W-1:0] med_idx_o
);
    import hh_median_pkg::*;

    hh_state_e        state_q;
    logic             slide_q;
    logic [IDX_W-1:0] fill_cnt_q;
    logic [IDX_W-1:0] col_base_q;
    logic [IDX_W-1:0] rd_ptr_q;
    logic [NIB_W-1:0] scan_ptr_q;
    logic [NIB_W-1:0] sel_hi_q;
    logic [CNT_W-1:0] acc_q;

    logic             fill_acc;
    logic [IDX_W-1:0] wr_addr;
    logic [IDX_W-1:0] fill_last;
    logic [SMP_W-1:0] old_smp, walk_smp;
    logic [BIN_W-1:0] hi_cnt, lo_cnt, step_bin;
    logic [IDX_W-1:0] lo_idx;
    logic [CNT_W-1:0] acc_next;
    logic             step_hit;
    logic             hi_clr, lo_clr, lo_upd;

    // Fill addressing and phase strobes.
    always_comb begin
        fill_acc  = (state_q == ST_FILL) && smp_valid_i;
        wr_addr   = slide_q ? (col_base_q + fill_cnt_q) : fill_cnt_q;
        fill_last = slide_q ? IDX_W'(K - 1) : IDX_W'(N - 1);
        hi_clr    = (state_q == ST_IDLE) && load_i;
        lo_clr    = (state_q == ST_SCAN_HI) && step_hit;
        lo_upd    = (state_q == ST_BUILD_LO) &&
                    (walk_smp[SMP_W-1:NIB_W] == sel_hi_q);
        step_bin  = (state_q == ST_SCAN_HI) ? hi_cnt : lo_cnt;
    end

    hh_win_store #(.N(N), .SMP_W(SMP_W), .IDX_W(IDX_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_acc),
        .wr_addr  (wr_addr),
        .wr_data  (smp_i),
        .rda_addr (wr_addr),
        .rda_data (old_smp),
        .rdb_addr (rd_ptr_q),
        .rdb_data (walk_smp)
    );

    hh_hist_hi #(.NIB_W(NIB_W), .BIN_W(BIN_W)) hist_hi_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hi_clr),
        .add_en  (fill_acc),
        .add_bin (smp_i[SMP_W-1:NIB_W]),
        .rem_en  (fill_acc && slide_q),
        .rem_bin (old_smp[SMP_W-1:NIB_W]),
        .rd_bin  (scan_ptr_q),
        .rd_cnt  (hi_cnt)
    );

    hh_hist_lo #(.NIB_W(NIB_W), .BIN_W(BIN_W), .IDX_W(IDX_W)) hist_lo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (lo_clr),
        .upd_en  (lo_upd),
        .upd_bin (walk_smp[NIB_W-1:0]),
        .upd_idx (rd_ptr_q),
        .rd_bin  (scan_ptr_q),
        .rd_cnt  (lo_cnt),
        .rd_idx  (lo_idx)
    );

    hh_scan_step #(.CNT_W(CNT_W), .BIN_W(BIN_W), .TARGET(HALF)) step_i (
        .acc_i (acc_q),
        .bin_i (step_bin),
        .acc_o (acc_next),
        .hit_o (step_hit)
    );

    // Sequencer: fill, coarse walk, fine rebuild, fine walk, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            slide_q    <= 1'b0;
            fill_cnt_q <= '0;
            col_base_q <= '0;
            rd_ptr_q   <= '0;
            scan_ptr_q <= '0;
            sel_hi_q   <= '0;
            acc_q      <= '0;
            done_o     <= 1'b0;
            median_o   <= '0;
            med_idx_o  <= '0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    fill_cnt_q <= '0;
                    if (load_i) begin
                        state_q    <= ST_FILL;
                        slide_q    <= 1'b0;
                        col_base_q <= '0;
                    end else if (slide_i) begin
                        state_q <= ST_FILL;
                        slide_q <= 1'b1;
                    end
                end
                ST_FILL: begin
                    if (smp_valid_i) begin
                        if (fill_cnt_q == fill_last) begin
                            state_q    <= ST_SCAN_HI;
                            scan_ptr_q <= '0;
                            acc_q      <= '0;
                            if (slide_q)
                                col_base_q <= (col_base_q == IDX_W'(N - K)) ?
                                              '0 : col_base_q + IDX_W'(K);
                        end else begin
                            fill_cnt_q <= fill_cnt_q + IDX_W'(1);
                        end
                    end
                end
                ST_SCAN_HI: begin
                    if (step_hit) begin
                        sel_hi_q <= scan_ptr_q;
                        rd_ptr_q <= '0;
                        state_q  <= ST_BUILD_LO;
                    end else begin
                        acc_q      <= acc_next;
                        scan_ptr_q <= scan_ptr_q + NIB_W'(1);
                    end
                end
                ST_BUILD_LO: begin
                    rd_ptr_q <= rd_ptr_q + IDX_W'(1);
                    if (rd_ptr_q == IDX_W'(N - 1)) begin
                        state_q    <= ST_SCAN_LO;
                        scan_ptr_q <= '0;
                    end
                end
                ST_SCAN_LO: begin
                    if (step_hit) begin
                        median_o  <= {sel_hi_q, scan_ptr_q};
                        med_idx_o <= lo_idx;
                        done_o    <= 1'b1;
                        state_q   <= ST_IDLE;
                    end else begin
                        acc_q      <= acc_next;
                        scan_ptr_q <= scan_ptr_q + NIB_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/hh_median_chk.sv
// Port-level protocol checks for hh_median, attached by bind.
module hh_median_chk #(
    parameter int SMP_W = 8,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic             slide_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [SMP_W-1:0] median_o,
    input logic [IDX_W-1:0] med_idx_o
);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && (load_i || slide_i)) |=> busy_o);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(median_o) && $stable(med_idx_o)));

endmodule

bind hh_median hh_median_chk #(.SMP_W(SMP_W), .IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .slide_i   (slide_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .median_o  (median_o),
    .med_idx_o (med_idx_o)
);

// File: tb/hh_median_tb_top.sv
// Directed bench for hh_median with a sorted-window reference model.
module hh_median_tb_top;

    localparam int N = 9;
    localparam int K = 3;
    localparam int HALF = (N + 1) / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic       slide_i = 1'b0;
    logic       smp_valid_i = 1'b0;
    logic [7:0] smp_i = '0;
    logic       busy_o, done_o;
    logic [7:0] median_o;
    logic [3:0] med_idx_o;

    int total = 0;
    int fails = 0;
    int win [N];
    int col_base = 0;
    int lcg = 12345;

    always #10 clk = ~clk;

    hh_median #(.N(N), .K(K), .SMP_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .slide_i(slide_i),
        .smp_valid_i(smp_valid_i), .smp_i(smp_i), .busy_o(busy_o),
        .done_o(done_o), .median_o(median_o), .med_idx_o(med_idx_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ref_result(output int med, output int idx);
        int srt [N];
        for (int i = 0; i < N; i++) srt[i] = win[i];
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N - 1 - i; j++)
                if (srt[j] > srt[j+1]) begin
                    int t = srt[j]; srt[j] = srt[j+1]; srt[j+1] = t;
                end
        med = srt[HALF-1];
        idx = 0;
        for (int i = 0; i < N; i++) if (win[i] == med) idx = i;
    endtask

    // One load (R2) or slide (R3) with result checks; inject>0 adds stray strobes (R8).
    task automatic run_op(input bit is_slide, input logic [7:0] s [N],
                          input int inject, input string tag);
        int cnt_smp = is_slide ? K : N;
        int med, idx, lat, cyc;
        if (is_slide) begin
            for (int r = 0; r < K; r++) win[col_base + r] = s[r];
            col_base = (col_base + K) % N;
        end else begin
            for (int i = 0; i < N; i++) win[i] = s[i];
            col_base = 0;
        end
        ref_result(med, idx);
        lat = N + (med >> 4) + (med & 15) + 2;
        if (is_slide) slide_i = 1'b1; else load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0; slide_i = 1'b0;
        check(is_slide ? "R3 busy after slide" : "R2 busy after load", busy_o, 1);
        for (int i = 0; i < cnt_smp; i++) begin
            smp_valid_i = 1'b1; smp_i = s[i];
            @(negedge clk);
        end
        smp_valid_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 500) begin
            @(negedge clk);
            cyc++;
            if (inject > 0 && cyc == inject) begin
                load_i = 1'b1; slide_i = 1'b1; smp_valid_i = 1'b1; smp_i = 8'h00;
            end else begin
                load_i = 1'b0; slide_i = 1'b0; smp_valid_i = 1'b0;
            end
        end
        load_i = 1'b0; slide_i = 1'b0; smp_valid_i = 1'b0;
        $display("op %s: median=%0h idx=%0d cycles=%0d", tag, median_o, med_idx_o, cyc);
        check({"R6 latency ", tag}, cyc, lat);
        check({"R4 median ", tag}, median_o, med);
        check({"R5 index ", tag}, med_idx_o, idx);
        check({"R7 busy low with done ", tag}, busy_o, 0);
        @(negedge clk);
        check({"R7 done one cycle ", tag}, done_o, 0);
    endtask

    task automatic t_example();
        logic [7:0] s [N] = '{8'h14, 8'h44, 8'h42, 8'hA3, 8'hA6, 8'hAB, 8'hC0, 8'hE4, 8'hFF};
        run_op(1'b0, s, 0, "example");
        check("R4 example value 0xA6", median_o, 8'hA6);
        check("R6 example latency recheck", N + 10 + 6 + 2, 27);
    endtask

    task automatic t_worst();
        logic [7:0] s [N];
        for (int i = 0; i < N; i++) s[i] = 8'hFF;
        run_op(1'b0, s, 0, "worst");
        check("R5 worst index last slot", med_idx_o, N - 1);
    endtask

    task automatic t_zero();
        logic [7:0] s [N];
        for (int i = 0; i < N; i++) s[i] = 8'h00;
        run_op(1'b0, s, 0, "zeros");
    endtask

    task automatic t_dups();
        logic [7:0] s [N] = '{8'h05, 8'h05, 8'h05, 8'h01, 8'h09, 8'h05, 8'h02, 8'h07, 8'h08};
        run_op(1'b0, s, 0, "dups");
        check("R5 dup highest slot", med_idx_o, 5);
    endtask

    task automatic t_idle_ignore();
        logic [7:0] m0 = median_o;
        logic [3:0] i0 = med_idx_o;
        for (int i = 0; i < 4; i++) begin
            smp_valid_i = 1'b1; smp_i = 8'hEE;
            @(negedge clk);
        end
        smp_valid_i = 1'b0;
        @(negedge clk);
        check("R9 median held while idle", median_o, m0);
        check("R9 index held while idle", med_idx_o, i0);
        check("R8 idle samples leave busy low", busy_o, 0);
    endtask

    task automatic t_random(input int loads, input int slides);
        logic [7:0] s [N];
        for (int l = 0; l < loads; l++) begin
            for (int i = 0; i < N; i++) begin
                lcg = (lcg * 1103515245 + 12345) & 32'h7FFFFFFF;
                s[i] = 8'((lcg >> 8) % ((l % 2) ? 256 : 24) + ((l % 2) ? 0 : 8'h70));
            end
            run_op(1'b0, s, 0, "rand load");
            for (int k = 0; k < slides; k++) begin
                for (int i = 0; i < N; i++) begin
                    lcg = (lcg * 1103515245 + 12345) & 32'h7FFFFFFF;
                    s[i] = 8'(lcg >> 8);
                end
                run_op(1'b1, s, (k == 1) ? 3 : 0, "rand slide");
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy reset", busy_o, 0);
        check("R1 done reset", done_o, 0);
        check("R1 median reset", median_o, 0);
        check("R1 index reset", med_idx_o, 0);
        t_example();
        t_worst();
        t_zero();
        t_dups();
        t_idle_ignore();
        t_random(3, 5);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule